// File: doc/BRIEF.md
# PHY Indirect Register Write Sequencer

This block writes values into a PHY's internal registers that are reachable only through an indirect pair of registers: one holds the target register address, the other carries data together with control strobes. A host raises a one-cycle start pulse with a 16-bit PHY register address and 16-bit data. The block then runs three ordered accesses on its PHY-side register-write bus: it loads the address, stages the data with the capture strobe, and repeats the same data with the write strobe to commit it.

Each access is a request held until the PHY acknowledges it. A build without acknowledge gives every access exactly one cycle. A typical use is to run a short list of calibration writes straight after PHY reset, one command per done pulse. Software can also reach the two indirect registers through a small write port. Each accepted software write becomes one access on the same bus, and the read-enable strobe is always forced low.

Top module: `phy_ind_wr`

## Requirements
- R1: After reset, busy_o, done_o and phy_req_o are low.
- R2: A start pulse accepted while idle gives exactly three accesses in this order: offset 0 with the address in bits 15:0; offset 4 with the data in bits 15:0 and bit 18 (capture) set; offset 4 with the same data and bit 17 (write) set. All other bits are zero.
- R3: Bit 16 (read enable) of phy_wdata_o is low on every access, including software accesses.
- R4: With USE_ACK=1, an access completes only at a clock edge where phy_req_o and phy_ack_i are both high. Until then phy_off_o and phy_wdata_o hold steady.
- R5: With USE_ACK=0, each access lasts exactly one cycle, so a command keeps busy_o high for three cycles.
- R6: busy_o rises at the edge that samples start_i and falls at the edge that completes the third access. In that same edge done_o rises for exactly one cycle.
- R7: A start pulse that arrives while busy_o is high is ignored.
- R8: A software write to offset 0 gives one access at offset 0 carrying bits 15:0. A write to offset 4 gives one access at offset 4 carrying bits 15:0, 17 and 18, with bit 16 cleared. Writes to any other offset are ignored. A software access raises busy_o but never done_o.
- R9: A software write is ignored while busy_o is high, and also when start_i is high in the same cycle (start has priority).
- R10: A new start may be applied in the cycle done_o is high. Two commands then run with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start pulse |
| addr_i | input | 16 | PHY register address for the command |
| data_i | input | 16 | Write data for the command |
| busy_o | output | 1 | An access sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a command has committed |
| sw_wr_i | input | 1 | Software write strobe |
| sw_off_i | input | 3 | Software byte offset (0 address, 4 data) |
| sw_wdata_i | input | 32 | Software write data |
| phy_req_o | output | 1 | Access request to the PHY |
| phy_off_o | output | 3 | Register offset of the access |
| phy_wdata_o | output | 32 | Word written by the access |
| phy_ack_i | input | 1 | PHY acknowledge of the current access |

## Verification
The command path is run with the two power-up calibration writes back to back, first with an immediate acknowledge and then with two wait cycles per access. This separates correct step ordering from correct holding of a request while it waits. Start pulses and software writes are injected in the middle of a command, and a software write is made to coincide with a start, to show that neither can insert an access. Software writes use all-ones words, a word with only the read-enable bit among the control bits set, and an unmapped offset, which exposes which upper bits pass and which are cleared. A second build without acknowledge is checked for one-cycle steps.

// File: rtl/phy_iw_pkg.sv
package phy_iw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CAP,
    ST_COMMIT,
    ST_SW
  } seq_state_e;

  // data-register strobe positions decoded by the PHY
  localparam int BIT_RD_EN = 16;
  localparam int BIT_WR_EN = 17;
  localparam int BIT_CAP   = 18;
endpackage

// File: rtl/phy_iw_step.sv
module phy_iw_step #(
  parameter bit USE_ACK = 1'b1
) (
  input  logic req_i,
  input  logic ack_i,
  output logic step_done_o
);
  generate
    if (USE_ACK) begin : g_ack
      assign step_done_o = req_i & ack_i;
    end else begin : g_fixed
      logic unused_ack;
      assign unused_ack  = ack_i;
      assign step_done_o = req_i;
    end
  endgenerate
endmodule

// File: rtl/phy_iw_ctrl.sv
module phy_iw_ctrl
  import phy_iw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       sw_wr_i,
  input  logic       sw_hit_i,
  input  logic       step_done_i,
  output seq_state_e state_o,
  output logic       launch_o,
  output logic       sw_load_o,
  output logic       busy_o,
  output logic       done_o
);
  seq_state_e state_q;
  logic       done_q;

  assign launch_o  = (state_q == ST_IDLE) && start_i;
  assign sw_load_o = (state_q == ST_IDLE) && !start_i && sw_wr_i && sw_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (launch_o)       state_q <= ST_ADDR;
          else if (sw_load_o) state_q <= ST_SW;
        end
        ST_ADDR:   if (step_done_i) state_q <= ST_CAP;
        ST_CAP:    if (step_done_i) state_q <= ST_COMMIT;
        ST_COMMIT: if (step_done_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        ST_SW:     if (step_done_i) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  AST_COMMIT_AFTER_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COMMIT) |-> ($past(state_q) == ST_CAP || $past(state_q) == ST_COMMIT)); // R2
  AST_HOLD_UNTIL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !step_done_i) |=> (state_q == $past(state_q))); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
endmodule

// File: rtl/phy_iw_fmt.sv
module phy_iw_fmt
  import phy_iw_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int BUS_W    = 32,
  parameter int OFF_W    = 3,
  parameter int ADDR_OFF = 0,
  parameter int DATA_OFF = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_state_e       state_i,
  input  logic             launch_i,
  input  logic             sw_load_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic [OFF_W-1:0] sw_off_i,
  input  logic [BUS_W-1:0] sw_wdata_i,
  output logic             sw_hit_o,
  output logic [OFF_W-1:0] off_o,
  output logic [BUS_W-1:0] wdata_o
);
  localparam logic [OFF_W-1:0] OFF_A = OFF_W'(ADDR_OFF);
  localparam logic [OFF_W-1:0] OFF_D = OFF_W'(DATA_OFF);

  logic             sw_is_data;
  logic [BUS_W-1:0] sw_word;
  logic [AW-1:0]    cmd_addr_q;
  logic [DW-1:0]    cmd_data_q;
  logic             sw_data_q;
  logic [BUS_W-1:0] sw_word_q;
  logic [BUS_W-1:0] addr_word;
  logic [BUS_W-1:0] data_word;
  logic             unused_sw_bits;

  assign sw_is_data     = (sw_off_i == OFF_D);
  assign sw_hit_o       = sw_is_data || (sw_off_i == OFF_A);
  assign unused_sw_bits = ^sw_wdata_i;

  // software word: read enable never passes
  always_comb begin
    sw_word = '0;
    if (sw_is_data) begin
      sw_word[DW-1:0]  = sw_wdata_i[DW-1:0];
      sw_word[BIT_WR_EN] = sw_wdata_i[BIT_WR_EN];
      sw_word[BIT_CAP]   = sw_wdata_i[BIT_CAP];
    end else begin
      sw_word[AW-1:0] = sw_wdata_i[AW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_addr_q <= '0;
      cmd_data_q <= '0;
      sw_data_q  <= 1'b0;
      sw_word_q  <= '0;
    end else begin
      if (launch_i) begin
        cmd_addr_q <= addr_i;
        cmd_data_q <= data_i;
      end
      if (sw_load_i) begin
        sw_data_q <= sw_is_data;
        sw_word_q <= sw_word;
      end
    end
  end

  always_comb begin
    addr_word = '0;
    addr_word[AW-1:0] = cmd_addr_q;
    data_word = '0;
    data_word[DW-1:0] = cmd_data_q;
  end

  always_comb begin
    off_o   = '0;
    wdata_o = '0;
    unique case (state_i)
      ST_ADDR: begin
        off_o   = OFF_A;
        wdata_o = addr_word;
      end
      ST_CAP: begin
        off_o   = OFF_D;
        wdata_o = data_word;
        wdata_o[BIT_CAP] = 1'b1;
      end
      ST_COMMIT: begin
        off_o   = OFF_D;
        wdata_o = data_word;
        wdata_o[BIT_WR_EN] = 1'b1;
      end
      ST_SW: begin
        off_o   = sw_data_q ? OFF_D : OFF_A;
        wdata_o = sw_word_q;
      end
      default: ;
    endcase
  end

  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CAP || state_i == ST_COMMIT) |-> $stable(cmd_data_q)); // R2
endmodule

// File: rtl/phy_ind_wr.sv
module phy_ind_wr
  import phy_iw_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int BUS_W    = 32,
  parameter int OFF_W    = 3,
  parameter int ADDR_OFF = 0,
  parameter int DATA_OFF = 4,
  parameter bit USE_ACK  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  output logic             busy_o,
  output logic             done_o,
  input  logic             sw_wr_i,
  input  logic [OFF_W-1:0] sw_off_i,
  input  logic [BUS_W-1:0] sw_wdata_i,
  output logic             phy_req_o,
  output logic [OFF_W-1:0] phy_off_o,
  output logic [BUS_W-1:0] phy_wdata_o,
  input  logic             phy_ack_i
);
  seq_state_e state;
  logic       launch, sw_load, sw_hit, step_done;

  phy_iw_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sw_wr_i    (sw_wr_i),
    .sw_hit_i   (sw_hit),
    .step_done_i(step_done),
    .state_o    (state),
    .launch_o   (launch),
    .sw_load_o  (sw_load),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  phy_iw_fmt #(
    .AW(AW), .DW(DW), .BUS_W(BUS_W), .OFF_W(OFF_W),
    .ADDR_OFF(ADDR_OFF), .DATA_OFF(DATA_OFF)
  ) u_fmt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .launch_i  (launch),
    .sw_load_i (sw_load),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .sw_off_i  (sw_off_i),
    .sw_wdata_i(sw_wdata_i),
    .sw_hit_o  (sw_hit),
    .off_o     (phy_off_o),
    .wdata_o   (phy_wdata_o)
  );

  phy_iw_step #(.USE_ACK(USE_ACK)) u_step (
    .req_i      (phy_req_o),
    .ack_i      (phy_ack_i),
    .step_done_o(step_done)
  );

  assign phy_req_o = busy_o;

  AST_RD_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |-> !phy_wdata_o[BIT_RD_EN]); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(busy_o)); // R6

  generate
    if (USE_ACK) begin : g_hold_chk
      AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phy_req_o && !phy_ack_i) |=>
          (phy_req_o && $stable(phy_off_o) && $stable(phy_wdata_o))); // R4
    end else begin : g_fixed_chk
      AST_ONE_CYCLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phy_req_o && !$past(phy_req_o)) |=> (phy_off_o != $past(phy_off_o) || phy_wdata_o != $past(phy_wdata_o) || !phy_req_o)); // R5
    end
  endgenerate
endmodule

// File: tb/test_phy_ind_wr.sv
module test_phy_ind_wr;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [15:0] addr = '0, data = '0;
  logic        sw_wr = 1'b0;
  logic [2:0]  sw_off = '0;
  logic [31:0] sw_wdata = '0;
  logic        busy, done, req, ack = 1'b0;
  logic [2:0]  off;
  logic [31:0] wdata;

  logic        n_start = 1'b0;
  logic [15:0] n_addr = '0, n_data = '0;
  logic        n_busy, n_done, n_req;
  logic [2:0]  n_off;
  logic [31:0] n_wdata;

  int checks = 0, failures = 0;
  int ack_lat = 0, wait_cnt = 0;
  string cur_req = "R2";
  logic [34:0] exp_q[$];

  always #10 clk = ~clk;

  phy_ind_wr i_phy_ind_wr (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .addr_i(addr), .data_i(data),
    .busy_o(busy), .done_o(done), .sw_wr_i(sw_wr), .sw_off_i(sw_off),
    .sw_wdata_i(sw_wdata), .phy_req_o(req), .phy_off_o(off),
    .phy_wdata_o(wdata), .phy_ack_i(ack)
  );

  phy_ind_wr #(.USE_ACK(1'b0)) i_phy_ind_wr_noack (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(n_start), .addr_i(n_addr), .data_i(n_data),
    .busy_o(n_busy), .done_o(n_done), .sw_wr_i(1'b0), .sw_off_i(3'd0),
    .sw_wdata_i(32'd0), .phy_req_o(n_req), .phy_off_o(n_off),
    .phy_wdata_o(n_wdata), .phy_ack_i(1'b0)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  // monitor: acknowledge after ack_lat wait cycles, compare each accepted beat
  always @(negedge clk) begin
    if (!req) begin
      ack <= 1'b0;
      wait_cnt = 0;
    end else if (wait_cnt == ack_lat) begin
      ack <= 1'b1;
      wait_cnt = 0;
      chk(wdata[16] == 1'b0, "R3", "read enable", {63'd0, wdata[16]}, 64'd0);
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected access", {29'd0, off, wdata}, 64'd0);
      end else begin
        logic [34:0] e;
        e = exp_q.pop_front();
        chk({off, wdata} == e, cur_req, "access", {29'd0, off, wdata}, {29'd0, e});
      end
    end else begin
      ack <= 1'b0;
      wait_cnt++;
    end
  end

  // driver: caller is at a negedge; poke injects start or sw write mid-command
  task automatic do_cmd(input logic [15:0] a, input logic [15:0] d, input int poke,
                        input bit poke_sw, input bit sw_same, input string rq);
    int cnt;
    cur_req = rq;
    exp_q.push_back({3'd0, 16'd0, a});
    exp_q.push_back({3'd4, 13'd0, 3'b100, d});
    exp_q.push_back({3'd4, 13'd0, 3'b010, d});
    start = 1'b1; addr = a; data = d;
    sw_wr = sw_same; sw_off = 3'd0; sw_wdata = 32'h0000_FFFF;
    @(negedge clk);
    cnt = 0;
    while (busy) begin
      cnt++;
      if (cnt == 1) chk(done == 1'b0, "R6", "done low while busy", {63'd0, done}, 64'd0);
      start = (cnt == poke) && !poke_sw;
      sw_wr = (cnt == poke) && poke_sw;
      addr = 16'h7777; data = 16'h3333;
      sw_off = 3'd4; sw_wdata = 32'h0004_1111;
      @(negedge clk);
    end
    start = 1'b0; sw_wr = 1'b0;
    chk(cnt == 3 * (ack_lat + 1), rq, "busy cycles", 64'(cnt), 64'(3 * (ack_lat + 1)));
    chk(done == 1'b1, "R6", "done at busy fall", {63'd0, done}, 64'd1);
  endtask

  task automatic sw_write(input logic [2:0] o, input logic [31:0] v, input bit valid,
                          input logic [31:0] e, input string rq);
    int cnt;
    bit saw_done;
    cur_req = rq;
    if (valid) exp_q.push_back({o, e});
    sw_wr = 1'b1; sw_off = o; sw_wdata = v;
    @(negedge clk);
    sw_wr = 1'b0;
    cnt = 0; saw_done = 1'b0;
    while (busy) begin
      cnt++;
      saw_done |= done;
      @(negedge clk);
    end
    saw_done |= done;
    chk(cnt == (valid ? ack_lat + 1 : 0), rq, "sw busy cycles", 64'(cnt),
        64'(valid ? ack_lat + 1 : 0));
    chk(!saw_done, "R8", "no done on sw access", {63'd0, saw_done}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog: actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req, "R1", "reset state", {61'd0, busy, done, req}, 64'd0);
    chk(!n_busy && !n_req, "R1", "reset state noack", {62'd0, n_busy, n_req}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // power-up pair, immediate ack, back to back (R10)
    ack_lat = 0;
    do_cmd(16'h0014, 16'hCE10, -1, 1'b0, 1'b0, "R2");
    do_cmd(16'h2004, 16'h82C7, -1, 1'b0, 1'b0, "R10");
    // wait states, with a start and a sw write injected mid-command
    ack_lat = 2;
    do_cmd(16'h0014, 16'hCE10, 2, 1'b0, 1'b0, "R7");
    do_cmd(16'h2004, 16'h82C7, 4, 1'b1, 1'b0, "R9");
    do_cmd(16'hFFFF, 16'hFFFF, -1, 1'b0, 1'b0, "R4");
    // start and sw write together
    ack_lat = 1;
    do_cmd(16'h0A5A, 16'h5A0A, -1, 1'b0, 1'b1, "R9");
    @(negedge clk);
    chk(!busy, "R7", "idle after command", {63'd0, busy}, 64'd0);

    sw_write(3'd0, 32'hABCD_1234, 1'b1, 32'h0000_1234, "R8");
    sw_write(3'd4, 32'hFFFF_FFFF, 1'b1, 32'h0006_FFFF, "R8");
    sw_write(3'd4, 32'h0001_5A5A, 1'b1, 32'h0000_5A5A, "R3");
    sw_write(3'd2, 32'h0000_BEEF, 1'b0, 32'h0, "R8");
    repeat (3) @(negedge clk);
    chk(!req, "R8", "unmapped offset no access", {63'd0, req}, 64'd0);

    // build without acknowledge: one cycle per step
    n_start = 1'b1; n_addr = 16'h2004; n_data = 16'h82C7;
    @(negedge clk);
    n_start = 1'b0;
    chk(n_req && {n_off, n_wdata} == {3'd0, 32'h0000_2004}, "R5", "noack step 1",
        {28'd0, n_req, n_off, n_wdata}, {28'd1, 3'd0, 32'h0000_2004});
    @(negedge clk);
    chk(n_req && {n_off, n_wdata} == {3'd4, 32'h0004_82C7}, "R5", "noack step 2",
        {28'd0, n_req, n_off, n_wdata}, {28'd1, 3'd4, 32'h0004_82C7});
    @(negedge clk);
    chk(n_req && {n_off, n_wdata} == {3'd4, 32'h0002_82C7}, "R5", "noack step 3",
        {28'd0, n_req, n_off, n_wdata}, {28'd1, 3'd4, 32'h0002_82C7});
    @(negedge clk);
    chk(!n_busy && n_done, "R5", "noack finish", {62'd0, n_busy, n_done}, 64'd1);

    chk(exp_q.size() == 0, "R2", "all accesses seen", 64'(exp_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule